// File: doc/BRIEF.md
# Instruction Cache Maintenance Sequencer

This block is the control front end of a small instruction cache. Software drives it through a small register port. It accepts three maintenance commands: turn the cache on, turn it off, and wipe every line. Each command runs for several cycles. When a command finishes, the block sets a sticky status bit for that command, and an interrupt line for that command can be enabled with a mask.

The block drives the valid-bit array of the cache through three signals: a line index, a clear strobe and a global enable. It also watches a flag from the fill logic that reports whether a line fill is still outstanding. It gates the hit indication from the lookup path and tells the fetch path when to go straight to memory. The expected software flow is: turn the cache off and wait for that to finish, wipe it and wait, change the code memory, then turn the cache back on and wait.

Top module: `icm_maint_ctrl`

## Requirements
- R1: After reset the cache is off and idle, the bypass output is high, all three status bits and all three mask bits are zero, and every interrupt output is low.
- R2: A write to address 0 issues commands from the data bits: bit 0 turns the cache on, bit 1 turns it off, bit 2 wipes it. When more than one bit is set, only one command runs, with wipe first, then off, then on.
- R3: An on command completes EN_LAT cycles after the write is accepted. In that same cycle the global enable rises and status bit 0 is set.
- R4: An off command drops the global enable in the cycle after the write. It completes only once the fill-busy input is low, and it then sets status bit 1.
- R5: A wipe command raises the clear strobe for exactly LINES cycles, with the index stepping 0, 1, ..., LINES-1. It then sets status bit 2. A wipe is accepted whether the cache is on or off, and it leaves the global enable unchanged.
- R6: Status bits are read at address 1. Each bit stays set until software writes a 1 to it at address 1. A completion in the same cycle as such a write leaves the bit set.
- R7: The mask is read and written at address 2, with bits 0 to 2 matching the status bits. Each interrupt output is high exactly when both its status bit and its mask bit are set.
- R8: Address 0 reads back bit 0 = cache on and bit 1 = busy. A command written while busy is ignored.
- R9: The hit output is never high while the cache is off or a wipe is running. The bypass output is the inverse of the global enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 3 | Register write data |
| reg_rdata | output | 3 | Register read data for reg_addr (combinational) |
| fill_busy | input | 1 | A line fill is outstanding |
| lookup_hit_raw | input | 1 | Ungated hit from the lookup path |
| hit | output | 1 | Gated hit |
| bypass | output | 1 | Fetches go to memory |
| vld_en | output | 1 | Global enable to the valid-bit array |
| vld_clr | output | 1 | Clear strobe for one valid bit |
| vld_idx | output | $clog2(LINES) | Line index to clear |
| irq_on_done | output | 1 | Interrupt: on command complete |
| irq_off_done | output | 1 | Interrupt: off command complete |
| irq_wipe_done | output | 1 | Interrupt: wipe complete |

## Verification
The hardest case to reach from the ports is an off command that has to wait for an outstanding fill. To create it, the bench holds fill_busy high before it issues the command. It then checks that the enable has already dropped, while completion and the status bit stay off for many cycles. Only when fill_busy is released does it check that the status bit appears one cycle later. A second hard case is a command arriving while a wipe runs. The bench writes an on command during the wipe. It then checks that the cache is still off and that only the wipe status bit is set once the wipe has ended.

// File: rtl/icm_pkg.sv
package icm_pkg;
    localparam int NUM_OPS  = 3;
    localparam int OP_ON    = 0;
    localparam int OP_OFF   = 1;
    localparam int OP_WIPE  = 2;

    localparam logic [1:0] A_CMD  = 2'd0;
    localparam logic [1:0] A_STAT = 2'd1;
    localparam logic [1:0] A_MASK = 2'd2;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ON   = 2'd1,
        ST_OFF  = 2'd2,
        ST_WIPE = 2'd3
    } icm_state_e;

    typedef logic [NUM_OPS-1:0] icm_ops_t;
endpackage

// File: rtl/icm_regs.sv
module icm_regs
    import icm_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       reg_we,
    input  logic [1:0] reg_addr,
    input  icm_ops_t   reg_wdata,
    output icm_ops_t   reg_rdata,
    input  icm_ops_t   done,
    input  logic       busy,
    input  logic       cache_on,
    output icm_ops_t   cmd_go,
    output icm_ops_t   status,
    output icm_ops_t   irq
);
    typedef struct packed {
        icm_ops_t stat;
        icm_ops_t mask;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (reg_we && reg_addr == A_STAT) begin
            r_d.stat = r_q.stat & ~reg_wdata;
        end
        if (reg_we && reg_addr == A_MASK) begin
            r_d.mask = reg_wdata;
        end
        // completions take priority over a same-cycle clear
        r_d.stat = r_d.stat | done;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        cmd_go = (reg_we && reg_addr == A_CMD) ? reg_wdata : '0;
    end

    always_comb begin
        unique case (reg_addr)
            A_CMD:   reg_rdata = {1'b0, busy, cache_on};
            A_STAT:  reg_rdata = r_q.stat;
            A_MASK:  reg_rdata = r_q.mask;
            default: reg_rdata = '0;
        endcase
    end

    assign status = r_q.stat;
    assign irq    = r_q.stat & r_q.mask;
endmodule

// File: rtl/icm_seq.sv
module icm_seq
    import icm_pkg::*;
#(
    parameter int LINES  = 64,
    parameter int EN_LAT = 4,
    localparam int IDX_W = $clog2(LINES),
    localparam int LAT_W = $clog2(EN_LAT + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  icm_ops_t         cmd_go,
    input  logic             fill_busy,
    output icm_ops_t         done,
    output logic             busy,
    output logic             cache_on,
    output logic             wiping,
    output logic [IDX_W-1:0] idx,
    output icm_state_e       state
);
    typedef struct packed {
        icm_state_e       st;
        logic             on;
        logic [IDX_W-1:0] idx;
        logic [LAT_W-1:0] lat;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d  = s_q;
        done = '0;
        unique case (s_q.st)
            ST_IDLE: begin
                if (cmd_go[OP_WIPE]) begin
                    s_d.st  = ST_WIPE;
                    s_d.idx = '0;
                end else if (cmd_go[OP_OFF]) begin
                    s_d.st = ST_OFF;
                    s_d.on = 1'b0;
                end else if (cmd_go[OP_ON]) begin
                    s_d.st  = ST_ON;
                    s_d.lat = '0;
                end
            end
            ST_ON: begin
                if (s_q.lat == LAT_W'(EN_LAT - 1)) begin
                    s_d.st      = ST_IDLE;
                    s_d.on      = 1'b1;
                    done[OP_ON] = 1'b1;
                end else begin
                    s_d.lat = s_q.lat + 1'b1;
                end
            end
            ST_OFF: begin
                if (!fill_busy) begin
                    s_d.st       = ST_IDLE;
                    done[OP_OFF] = 1'b1;
                end
            end
            ST_WIPE: begin
                if (s_q.idx == IDX_W'(LINES - 1)) begin
                    s_d.st        = ST_IDLE;
                    done[OP_WIPE] = 1'b1;
                end else begin
                    s_d.idx = s_q.idx + 1'b1;
                end
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{st: ST_IDLE, on: 1'b0, idx: '0, lat: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign busy     = (s_q.st != ST_IDLE);
    assign cache_on = s_q.on;
    assign wiping   = (s_q.st == ST_WIPE);
    assign idx      = s_q.idx;
    assign state    = s_q.st;
endmodule

// File: rtl/icm_fetch_gate.sv
module icm_fetch_gate (
    input  logic cache_on,
    input  logic wiping,
    input  logic lookup_hit_raw,
    output logic hit,
    output logic bypass
);
    always_comb begin
        hit    = lookup_hit_raw && cache_on && !wiping;
        bypass = !cache_on;
    end
endmodule

// File: rtl/icm_maint_ctrl.sv
module icm_maint_ctrl
    import icm_pkg::*;
#(
    parameter int LINES  = 64,
    parameter int EN_LAT = 4,
    localparam int IDX_W = $clog2(LINES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_we,
    input  logic [1:0]       reg_addr,
    input  logic [2:0]       reg_wdata,
    output logic [2:0]       reg_rdata,
    input  logic             fill_busy,
    input  logic             lookup_hit_raw,
    output logic             hit,
    output logic             bypass,
    output logic             vld_en,
    output logic             vld_clr,
    output logic [IDX_W-1:0] vld_idx,
    output logic             irq_on_done,
    output logic             irq_off_done,
    output logic             irq_wipe_done
);
    icm_ops_t   cmd_go_w, done_w, status_w, irq_w;
    logic       busy_w, on_w, wiping_w;
    icm_state_e state_w;

    icm_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .done      (done_w),
        .busy      (busy_w),
        .cache_on  (on_w),
        .cmd_go    (cmd_go_w),
        .status    (status_w),
        .irq       (irq_w)
    );

    icm_seq #(.LINES(LINES), .EN_LAT(EN_LAT)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_go    (cmd_go_w),
        .fill_busy (fill_busy),
        .done      (done_w),
        .busy      (busy_w),
        .cache_on  (on_w),
        .wiping    (wiping_w),
        .idx       (vld_idx),
        .state     (state_w)
    );

    icm_fetch_gate u_gate (
        .cache_on       (on_w),
        .wiping         (wiping_w),
        .lookup_hit_raw (lookup_hit_raw),
        .hit            (hit),
        .bypass         (bypass)
    );

    assign vld_en        = on_w;
    assign vld_clr       = wiping_w;
    assign irq_on_done   = irq_w[OP_ON];
    assign irq_off_done  = irq_w[OP_OFF];
    assign irq_wipe_done = irq_w[OP_WIPE];
endmodule

// File: rtl/icm_maint_chk.sv
module icm_maint_chk
    import icm_pkg::*;
#(
    parameter int IDX_W = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             hit,
    input logic             vld_en,
    input logic             vld_clr,
    input logic [IDX_W-1:0] vld_idx,
    input logic             fill_busy,
    input logic             busy,
    input icm_state_e       state,
    input icm_ops_t         done,
    input icm_ops_t         status
);
    AST_HIT_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> (vld_en && !vld_clr)); // R9

    AST_WIPE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_clr && $past(vld_clr)) |-> (vld_idx == $past(vld_idx) + 1'b1)); // R5

    AST_OFF_DRAINED: assert property (@(posedge clk) disable iff (!rst_n)
        done[OP_OFF] |-> !fill_busy); // R4

    AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (done != '0) |=> ((status & $past(done)) == $past(done))); // R6

    AST_BUSY_HOLDS_OP: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> (state == $past(state))); // R8

    AST_DONE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(done)); // R2
endmodule

bind icm_maint_ctrl icm_maint_chk #(.IDX_W(IDX_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .hit       (hit),
    .vld_en    (vld_en),
    .vld_clr   (vld_clr),
    .vld_idx   (vld_idx),
    .fill_busy (fill_busy),
    .busy      (busy_w),
    .state     (state_w),
    .done      (done_w),
    .status    (status_w)
);

// File: tb/tb_icm_maint_ctrl.sv
module tb_icm_maint_ctrl;
    localparam int LINES  = 64;
    localparam int EN_LAT = 4;
    localparam int IDX_W  = $clog2(LINES);
    localparam int NV     = 14;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             reg_we = 1'b0;
    logic [1:0]       reg_addr = 2'd0;
    logic [2:0]       reg_wdata = 3'd0;
    logic [2:0]       reg_rdata;
    logic             fill_busy = 1'b0;
    logic             lookup_hit_raw = 1'b0;
    logic             hit, bypass, vld_en, vld_clr;
    logic [IDX_W-1:0] vld_idx;
    logic             irq_on_done, irq_off_done, irq_wipe_done;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    icm_maint_ctrl #(.LINES(LINES), .EN_LAT(EN_LAT)) dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .fill_busy(fill_busy),
        .lookup_hit_raw(lookup_hit_raw), .hit(hit), .bypass(bypass),
        .vld_en(vld_en), .vld_clr(vld_clr), .vld_idx(vld_idx),
        .irq_on_done(irq_on_done), .irq_off_done(irq_off_done),
        .irq_wipe_done(irq_wipe_done)
    );

    // vector: write addr, write data, wait cycles, read addr, expected read
    localparam logic [17:0] VEC [NV] = '{
        {2'd3, 3'd0, 8'd0,  2'd0, 3'b000}, // R1 off and idle
        {2'd2, 3'd7, 8'd0,  2'd2, 3'b111}, // R7 mask readback
        {2'd0, 3'd1, 8'd0,  2'd0, 3'b010}, // R8 busy during on
        {2'd3, 3'd0, 8'd3,  2'd0, 3'b001}, // R3 on after EN_LAT
        {2'd3, 3'd0, 8'd0,  2'd1, 3'b001}, // R3 status bit 0
        {2'd1, 3'd1, 8'd0,  2'd1, 3'b000}, // R6 write-one clear
        {2'd0, 3'd2, 8'd1,  2'd1, 3'b010}, // R4 off done
        {2'd3, 3'd0, 8'd0,  2'd0, 3'b000}, // R4 cache now off
        {2'd0, 3'd4, 8'd0,  2'd0, 3'b010}, // R5 wipe accepted while off
        {2'd3, 3'd0, 8'd64, 2'd1, 3'b110}, // R5 wipe done, R6 earlier bit kept
        {2'd1, 3'd6, 8'd0,  2'd1, 3'b000}, // R6 clear two bits
        {2'd0, 3'd7, 8'd70, 2'd1, 3'b100}, // R2 wipe wins
        {2'd3, 3'd0, 8'd0,  2'd0, 3'b000}, // R2 on not run
        {2'd1, 3'd7, 8'd0,  2'd1, 3'b000}  // R6 clear all
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [2:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [2:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic wait_cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic finish_run;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [2:0] rv;
        int         cnt, bad;

        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset outputs
        chk("R1 bypass", bypass, 1);
        chk("R1 irqs", {irq_on_done, irq_off_done, irq_wipe_done}, 0);
        rd(2'd1, rv); chk("R1 status", rv, 0);
        rd(2'd2, rv); chk("R1 mask", rv, 0);

        for (int i = 0; i < NV; i++) begin
            wr(VEC[i][17:16], VEC[i][15:13]);
            wait_cyc(int'(VEC[i][12:5]));
            rd(VEC[i][4:3], rv);
            chk($sformatf("vector %0d", i), rv, VEC[i][2:0]);
        end

        // R3 exact completion cycle
        wr(2'd0, 3'b001);
        wait_cyc(EN_LAT - 1);
        chk("R3 not yet on", vld_en, 0);
        rd(2'd1, rv); chk("R3 status not yet", rv, 0);
        wait_cyc(1);
        chk("R3 on", vld_en, 1);
        rd(2'd1, rv); chk("R3 status set", rv, 3'b001);
        wr(2'd1, 3'b111);

        // R9 hit passes when on and idle
        lookup_hit_raw = 1'b1;
        #1;
        chk("R9 hit when on", hit, 1);

        // R5 walk while on, R9 hit blocked during wipe
        wr(2'd0, 3'b100);
        cnt = 0; bad = 0;
        while (vld_clr && cnt < 200) begin
            if (vld_idx != IDX_W'(cnt)) bad++;
            if (hit) bad++;
            cnt++;
            @(negedge clk);
        end
        chk("R5 strobe count", cnt, LINES);
        chk("R5 index order and R9 gating", bad, 0);
        chk("R5 enable unchanged", vld_en, 1);
        rd(2'd1, rv); chk("R5 status", rv, 3'b100);
        wr(2'd1, 3'b111);

        // R4 drain: off waits for fill
        fill_busy = 1'b1;
        wr(2'd0, 3'b010);
        chk("R4 enable dropped", vld_en, 0);
        chk("R9 bypass when off", bypass, 1);
        #1;
        chk("R9 no hit when off", hit, 0);
        wait_cyc(10);
        rd(2'd1, rv); chk("R4 held by fill", rv, 0);
        rd(2'd0, rv); chk("R4 still busy", rv, 3'b010);
        fill_busy = 1'b0;
        wait_cyc(1);
        rd(2'd1, rv); chk("R4 done after fill", rv, 3'b010);
        wr(2'd1, 3'b111);
        lookup_hit_raw = 1'b0;

        // R8 command during wipe ignored
        wr(2'd0, 3'b100);
        wr(2'd0, 3'b001);
        wait_cyc(80);
        rd(2'd0, rv); chk("R8 on ignored", rv, 0);
        rd(2'd1, rv); chk("R8 only wipe status", rv, 3'b100);
        wr(2'd1, 3'b111);

        // R7 interrupt masking
        wr(2'd2, 3'b000);
        wr(2'd0, 3'b001);
        wait_cyc(10);
        chk("R7 masked irq", irq_on_done, 0);
        rd(2'd1, rv); chk("R7 status under mask", rv, 3'b001);
        wr(2'd2, 3'b001);
        chk("R7 irq on", {irq_wipe_done, irq_off_done, irq_on_done}, 3'b001);
        wr(2'd1, 3'b001);
        chk("R7 irq cleared", irq_on_done, 0);

        finish_run();
    end
endmodule